// File: doc/BRIEF.md
# Striped Vector Operand Scratchpad

This block is an on-chip scratchpad built from several equally sized memory banks that are all read in the same clock cycle. Consecutive word addresses are interleaved across the banks, so any run of bank-count consecutive words touches every bank exactly once, wherever the run begins. A vector consumer asks for an operand by giving a start word address and an element count. The scratchpad then streams the operand out as a series of waves, one wave per clock, each wave holding one element for each SIMD lane.

A wave that begins part-way through a bank row needs different rows from different banks. The block computes a row for each bank, reads all banks at once, and rotates the returned words so that lane 0 always holds the first element of the wave. Each wave comes with a lane-enable mask. The mask is cleared for lanes past the end of the vector, so a final wave may be partial. A separate single-word write port loads the memory.

A request is accepted only while the block is idle. A one-cycle completion pulse follows the last wave.

Top module: `vsp_scratchpad`

## Requirements
- R1: After reset is released, `rd_busy`, `wave_valid` and `rd_done` are all 0 until a request is accepted.
- R2: A write with `wr_en` high stores `wr_data` at word address `wr_addr`. The word lives in bank `wr_addr mod NUM_BANKS` at row `wr_addr div NUM_BANKS`, the bank being selected by the low log2(NUM_BANKS) address bits. Any later read of that address returns the new value.
- R3: For a request with start address s, lane l of wave k carries the word stored at address s + k*NUM_BANKS + l for every enabled lane, for any s, aligned or not.
- R4: Waves come out on consecutive cycles. If the request is accepted at clock edge 0, wave k has `wave_valid` high in the cycle after edge k+1.
- R5: Lane l of wave k is enabled (`wave_lane_en[l]` = 1) exactly when k*NUM_BANKS + l < length. Disabled lanes present all-zero data.
- R6: A request of length L > 0 produces exactly ceil(L / NUM_BANKS) waves.
- R7: `rd_done` is high for one cycle, in the cycle right after the last wave. `rd_busy` is high from the cycle after acceptance through the `rd_done` cycle, and low in the next cycle.
- R8: A request of length 0 produces no wave and raises `rd_done` in the cycle right after the accepting edge.
- R9: `rd_req` is ignored while `rd_busy` is high. The wave data, masks and timing of the running request are unchanged.
- R10: Addresses wrap modulo the scratchpad depth, so a vector that runs past the top word continues from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write one word this cycle |
| wr_addr | input | ADDR_W | Word address for the write |
| wr_data | input | DATA_W | Word to write |
| rd_req | input | 1 | Vector read request, sampled while idle |
| rd_start | input | ADDR_W | First word address of the vector |
| rd_len | input | LEN_W | Element count of the vector |
| rd_busy | output | 1 | Request in progress, new requests ignored |
| rd_done | output | 1 | One-cycle completion pulse |
| wave_valid | output | 1 | A wave is presented this cycle |
| wave_lane_en | output | NUM_BANKS | Per-lane element valid mask |
| wave_data | output | NUM_BANKS*DATA_W | Lane data, lane 0 in the low bits |

## Verification
A wrong per-bank row choice or a wrong rotation amount shows up as a wrong word in some lane of the first wave that starts at an unaligned address. That word appears two cycles after the request edge. For this reason every start address of the small default memory is paired with lengths on both sides of each multiple of the bank count. A wrong remaining-length count shows up in the mask or in the done pulse at the end of the same vector. Stray requests are held high during runs so that any reload of the sequencer corrupts the waves that follow at once.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_DRAIN = 2'd2,
    SEQ_FIN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/vsp_bank.sv
module vsp_bank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rd_data_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_row] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= mem[rd_row];
    end
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/vsp_wave_seq.sv
module vsp_wave_seq
  import vsp_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 6,
  parameter int LEN_W     = 8,
  localparam int CNT_W    = $clog2(NUM_BANKS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] start,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic              done,
  output logic              issue,
  output logic [ADDR_W-1:0] issue_addr,
  output logic [CNT_W-1:0]  issue_cnt
);
  localparam logic [LEN_W-1:0]  STEP_LEN  = LEN_W'(NUM_BANKS);
  localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(NUM_BANKS);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req) begin
          addr_d   = start;
          remain_d = len;
          state_d  = (len == '0) ? SEQ_FIN : SEQ_ISSUE;
        end
      end
      SEQ_ISSUE: begin
        addr_d = addr_q + STEP_ADDR;
        if (remain_q <= STEP_LEN) begin
          remain_d = '0;
          state_d  = SEQ_DRAIN;
        end else begin
          remain_d = remain_q - STEP_LEN;
        end
      end
      SEQ_DRAIN: state_d = SEQ_FIN;
      SEQ_FIN:   state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
    end
  end

  assign busy       = (state_q != SEQ_IDLE);
  assign done       = (state_q == SEQ_FIN);
  assign issue      = (state_q == SEQ_ISSUE);
  assign issue_addr = addr_q;
  assign issue_cnt  = (remain_q > STEP_LEN) ? CNT_W'(NUM_BANKS) : remain_q[CNT_W-1:0];

  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && req && len == '0) |=> done); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> (remain_q <= $past(remain_q))); // R9
endmodule

// File: rtl/vsp_align.sv
module vsp_align #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32,
  localparam int BSEL_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = BSEL_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issue,
  input  logic [BSEL_W-1:0]           shift,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic                        wave_valid,
  output logic [NUM_BANKS-1:0]        lane_en,
  output logic [NUM_BANKS*DATA_W-1:0] lane_data
);
  logic                 vld_q;
  logic [BSEL_W-1:0]    shift_q;
  logic [NUM_BANKS-1:0] mask_q, mask_d;

  for (genvar l = 0; l < NUM_BANKS; l++) begin : g_mask
    assign mask_d[l] = (CNT_W'(l) < cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      shift_q <= '0;
      mask_q  <= '0;
    end else begin
      vld_q <= issue;
      if (issue) begin
        shift_q <= shift;
        mask_q  <= mask_d;
      end
    end
  end

  for (genvar l = 0; l < NUM_BANKS; l++) begin : g_lane
    logic [BSEL_W-1:0] src;
    assign src = shift_q + BSEL_W'(l);
    assign lane_data[l*DATA_W +: DATA_W] =
      (vld_q && mask_q[l]) ? bank_rdata[src*DATA_W +: DATA_W] : '0;
  end

  assign wave_valid = vld_q;
  assign lane_en    = vld_q ? mask_q : '0;

  AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    wave_valid |-> (lane_en[0] && ((lane_en & (lane_en + 1'b1)) == '0))); // R5
endmodule

// File: rtl/vsp_scratchpad.sv
module vsp_scratchpad #(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 16,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  localparam int BSEL_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(ROWS),
  localparam int ADDR_W   = BSEL_W + ROW_W,
  localparam int CNT_W    = BSEL_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        rd_req,
  input  logic [ADDR_W-1:0]           rd_start,
  input  logic [LEN_W-1:0]            rd_len,
  output logic                        rd_busy,
  output logic                        rd_done,
  output logic                        wave_valid,
  output logic [NUM_BANKS-1:0]        wave_lane_en,
  output logic [NUM_BANKS*DATA_W-1:0] wave_data
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              issue;
  logic [ADDR_W-1:0] issue_addr;
  logic [CNT_W-1:0]  issue_cnt;

  vsp_wave_seq #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (rd_req),
    .start     (rd_start),
    .len       (rd_len),
    .busy      (rd_busy),
    .done      (rd_done),
    .issue     (issue),
    .issue_addr(issue_addr),
    .issue_cnt (issue_cnt)
  );

  logic [BSEL_W-1:0]           start_bank;
  logic [ROW_W-1:0]            base_row;
  logic [BSEL_W-1:0]           wr_bank;
  logic [ROW_W-1:0]            wr_row;
  logic [NUM_BANKS*DATA_W-1:0] bank_rdata;

  assign start_bank = issue_addr[BSEL_W-1:0];
  assign base_row   = issue_addr[ADDR_W-1:BSEL_W];
  assign wr_bank    = wr_addr[BSEL_W-1:0];
  assign wr_row     = wr_addr[ADDR_W-1:BSEL_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ROW_W-1:0] rd_row;
    // banks below the start bank hold the tail of the wave one row further on
    assign rd_row = base_row + ROW_W'((BSEL_W'(b) < start_bank) ? 1 : 0);

    vsp_bank #(
      .DATA_W(DATA_W),
      .ROWS  (ROWS)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_en  (wr_en && (wr_bank == BSEL_W'(b))),
      .wr_row (wr_row),
      .wr_data(wr_data),
      .rd_en  (issue),
      .rd_row (rd_row),
      .rd_data(bank_rdata[b*DATA_W +: DATA_W])
    );
  end

  vsp_align #(
    .NUM_BANKS(NUM_BANKS),
    .DATA_W   (DATA_W)
  ) u_align (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .issue     (issue),
    .shift     (start_bank),
    .cnt       (issue_cnt),
    .bank_rdata(bank_rdata),
    .wave_valid(wave_valid),
    .lane_en   (wave_lane_en),
    .lane_data (wave_data)
  );

  AST_WAVE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wave_valid |-> rd_busy); // R4
  AST_DONE_NO_WAVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_done |-> !wave_valid); // R7
endmodule

// File: tb/sim_vsp_scratchpad.sv
module sim_vsp_scratchpad;
  localparam int N     = 4;
  localparam int ROWS  = 16;
  localparam int DW    = 32;
  localparam int LW    = 8;
  localparam int AW    = 6;
  localparam int DEPTH = N * ROWS;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_req;
  logic [AW-1:0] rd_start;
  logic [LW-1:0] rd_len;
  logic          rd_busy;
  logic          rd_done;
  logic          wave_valid;
  logic [N-1:0]  wave_lane_en;
  logic [N*DW-1:0] wave_data;

  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;

  vsp_scratchpad #(
    .NUM_BANKS(N), .ROWS(ROWS), .DATA_W(DW), .LEN_W(LW)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_start(rd_start), .rd_len(rd_len),
    .rd_busy(rd_busy), .rd_done(rd_done),
    .wave_valid(wave_valid), .wave_lane_en(wave_lane_en), .wave_data(wave_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int salt);
    return (32'(a + 1) * 32'h9E3779B9) ^ 32'(salt);
  endfunction

  task automatic write_word(input int a, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = d;
    model[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_vec(input int start, input int len, input bit noise);
    int w;
    w = (len + N - 1) / N;
    rd_req   = 1'b1;
    rd_start = AW'(start);
    rd_len   = LW'(len);
    @(negedge clk);
    chk(rd_busy == 1'b1, "R7 busy after accept", 32'(rd_busy), 32'd1);
    chk(wave_valid == 1'b0, "R4 no wave in accept cycle", 32'(wave_valid), 32'd0);
    if (len == 0) begin
      rd_req = 1'b0;
      chk(rd_done == 1'b1, "R8 zero length done", 32'(rd_done), 32'd1);
      @(negedge clk);
      chk(rd_busy == 1'b0 && rd_done == 1'b0, "R8 idle after zero length",
          {30'd0, rd_busy, rd_done}, 32'd0);
      return;
    end
    chk(rd_done == 1'b0, "R7 no early done", 32'(rd_done), 32'd0);
    if (noise) begin
      rd_start = ~AW'(start);
      rd_len   = LW'(len ^ 3);
    end else begin
      rd_req = 1'b0;
    end
    for (int c = 1; c <= w + 1; c++) begin
      @(negedge clk);
      if (c <= w) begin
        chk(wave_valid == 1'b1, "R4 wave each cycle", 32'(wave_valid), 32'd1);
        chk(rd_done == 1'b0, "R6 no done during waves", 32'(rd_done), 32'd0);
        for (int l = 0; l < N; l++) begin
          int idx;
          bit en;
          logic [31:0] exp;
          idx = (c - 1) * N + l;
          en  = (idx < len);
          exp = en ? model[(start + idx) % DEPTH] : 32'd0;
          chk(wave_lane_en[l] == en, noise ? "R9 lane enable" : "R5 lane enable",
              32'(wave_lane_en[l]), 32'(en));
          chk(wave_data[l*DW +: DW] == exp,
              noise ? "R9 lane data" : ((start + idx >= DEPTH) ? "R10 wrapped data" : "R3 lane data"),
              wave_data[l*DW +: DW], exp);
        end
      end else begin
        rd_req = 1'b0;
        chk(rd_done == 1'b1, "R7 done after last wave", 32'(rd_done), 32'd1);
        chk(wave_valid == 1'b0, "R6 wave count", 32'(wave_valid), 32'd0);
        chk(rd_busy == 1'b1, "R7 busy in done cycle", 32'(rd_busy), 32'd1);
      end
    end
    @(negedge clk);
    chk(rd_busy == 1'b0 && rd_done == 1'b0, "R7 idle after done",
        {30'd0, rd_busy, rd_done}, 32'd0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    rd_req   = 1'b0;
    rd_start = '0;
    rd_len   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_busy == 1'b0, "R1 busy low", 32'(rd_busy), 32'd0);
    chk(wave_valid == 1'b0, "R1 no wave", 32'(wave_valid), 32'd0);
    chk(rd_done == 1'b0, "R1 no done", 32'(rd_done), 32'd0);

    // R2: fill every word through the write port
    for (int a = 0; a < DEPTH; a++) write_word(a, pat(a, 0));

    // R3 R5 R6 R10: every start with lengths around each bank multiple
    for (int s = 0; s < DEPTH; s++) begin
      for (int len = 0; len <= 13; len++) begin
        run_vec(s, len, ((s + len) % 3) == 0);
      end
    end

    // R10: long run wrapping the memory several times
    run_vec(61, 200, 1'b0);

    // R2: overwrite scattered words and read them back unaligned
    for (int a = 0; a < DEPTH; a += 5) write_word(a, pat(a, 32'h5A5A0000 + a));
    run_vec(3, 64, 1'b0);
    run_vec(62, 9, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule